// File: doc/BRIEF.md
# Sawtooth PWM Timer Channel

A single timer channel that turns one 32-bit sawtooth counter into two PWM outputs. Software programs it through a small synchronous register port: it sets a period, two compare values and an action code plus an output enable for each pin. It then picks a prescale ratio, a mode and a count direction, and sets or clears a run bit. Each time the counter passes its compare value a pin toggles. At the end of each period the pin is forced back to a fixed level, so the compare value sets the duty cycle.

The counter advances once per prescaled tick. When counting up it runs from 0 to the period value and wraps to 0. When counting down it runs from the period value to 0 and reloads the period. Each wrap raises a one-cycle overflow pulse. While the counter is stopped both outputs are held low, and the counter can be loaded directly through the register port. The mode and prescale fields are locked while the counter runs.

Top module: `pwm_saw_timer`

## Requirements
- R1: After reset, control reads 0, direction reads 1 (up), pin config reads 0, counter reads 0, period reads 0xFFFFFFFF, compares read 0, and pin_o, pin_oe_o and ovf_o are 0.
- R2: The byte addresses are: control 0x2C, direction 0x30 (bits 1:0), pin config 0x34, counter 0x48, compare A 0x4C, compare B 0x50, period 0x64. Control holds run at bit 0, mode at 18:16 and prescale select at 26:24. Pin config holds pin A's code at 4:0 and enable at 8, and pin B's code at 20:16 and enable at 24. Unused bits and unmapped addresses read 0.
- R3: A write to control while the counter runs updates only the run bit; mode and prescale select keep their values.
- R4: The counter advances once every 1 << (2*sel) clock cycles for sel 0..5. Select values 6 and 7 read back as written but divide by 1024. The prescaler restarts from zero at every start.
- R5: With direction bit 0 set and mode 0, the counter counts 0..period on successive ticks and wraps to 0. ovf_o is high for the one cycle in which the counter first shows 0.
- R6: With direction bit 0 clear, the counter counts down to 0 and then reloads the period value, pulsing ovf_o in the cycle it shows the period.
- R7: A mode value other than 0 freezes the counter while it runs.
- R8: Action code 0x1B sets the pin level high at start and at period end; code 0x07 sets it low at both. Both codes toggle the level on the tick that leaves the count equal to the pin's compare value. Pin 0 (A) uses compare A and pin 1 (B) uses compare B.
- R9: When a compare match and a period end fall on the same tick, the period-end level wins.
- R10: Any other action code leaves the pin level unchanged at start, at period end and at compare match.
- R11: pin_o[i] is 0 whenever the counter is stopped or pin i's enable bit is 0; pin_oe_o[i] equals pin i's enable bit.
- R12: A write to the counter address loads the counter, and the value reads back at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for addr_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_o | output | 2 | PWM outputs, bit 0 = A, bit 1 = B |
| pin_oe_o | output | 2 | Output enables, bit 0 = A, bit 1 = B |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
The bench sets a compare value equal to the period. A design that let the toggle win there would flip the pin every period instead of holding it at the end level. It writes the mode and prescale fields while the counter runs; a design without the lock would change ratio mid-period. It checks the divide count cycle by cycle at ratios 4 and 1024 (select 7), which catches an off-by-one in the prescale terminal count or a missing clamp. It also runs the counter downward to check the reload value and where the overflow pulse falls, and it checks that an unknown action code holds a level left over from an earlier run.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_PINS = 2;
  localparam int SEL_W    = 3;
  localparam int MODE_W   = 3;
  localparam int CODE_W   = 5;
  localparam int MAX_SEL  = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h2C;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 8'h34;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 8'h4C;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 8'h50;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 8'h64;

  localparam int RUN_BIT    = 0;
  localparam int MODE_LSB   = 16;
  localparam int SEL_LSB    = 24;
  localparam int PIN_STRIDE = 16;
  localparam int OE_OFS     = 8;

  localparam logic [MODE_W-1:0] MODE_SAW = '0;
  localparam logic [CODE_W-1:0] ACT_HI   = 5'h1B;
  localparam logic [CODE_W-1:0] ACT_LO   = 5'h07;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 * MAX_SEL;

  logic [DIV_W-1:0] div_q, limit;
  logic [SEL_W-1:0] sel_eff;

  always_comb begin
    sel_eff = (sel_i > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_i;
    limit   = '0;
    for (int i = 0; i < MAX_SEL; i++)
      if (i < int'(sel_eff)) limit[2*i +: 2] = 2'b11;
  end

  assign tick_o = run_i && (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // ratio > 1 never yields back-to-back ticks
  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> !tick_o);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         end_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q, at_end;

  assign at_end = up_i ? (cnt_q >= period_i) : (cnt_q == '0);
  assign end_o  = step_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= end_o;
      if (load_i)        cnt_q <= load_val_i;
      else if (step_i) begin
        if (up_i)        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        else             cnt_q <= at_end ? period_i : cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_up_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && up_i && !end_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_up_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && up_i) |=> (ovf_q && cnt_q == '0));
  assert_down_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !up_i) |=> cnt_q == $past(period_i));
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin
  import pwm_saw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              match_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              oe_i,
  output logic              pin_o,
  output logic              oe_o
);
  logic level_q, known, fixed_lvl;

  assign known     = (code_i == ACT_HI) || (code_i == ACT_LO);
  assign fixed_lvl = (code_i == ACT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            level_q <= 1'b0;
    else if (known && (start_i || end_i))   level_q <= fixed_lvl;  // end beats match
    else if (known && match_i)              level_q <= ~level_q;
  end

  assign pin_o = run_i && oe_i && level_q;
  assign oe_o  = oe_i;

  assert_end_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && code_i == ACT_HI) |=> level_q);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |=> $stable(level_q));
endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
  import pwm_saw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic              ovf_o
);
  logic                              run_q;
  logic [MODE_W-1:0]                 mode_q;
  logic [SEL_W-1:0]                  sel_q;
  logic [1:0]                        dir_q;
  logic [NUM_PINS-1:0][CODE_W-1:0]   code_q;
  logic [NUM_PINS-1:0]               oe_q;
  logic [NUM_PINS-1:0][DATA_W-1:0]   cmp_q;
  logic [DATA_W-1:0]                 per_q, cnt;
  logic wr_ctrl, start, tick, step, cnt_load, per_end;
  logic [NUM_PINS-1:0] match;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign start    = wr_ctrl && wdata_i[RUN_BIT] && !run_q;
  assign cnt_load = wr_en_i && (addr_i == ADDR_CNT);
  assign step     = tick && (mode_q == MODE_SAW) && !cnt_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      sel_q  <= '0;
      dir_q  <= 2'b01;
      code_q <= '0;
      oe_q   <= '0;
      cmp_q  <= '0;
      per_q  <= '1;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          run_q <= wdata_i[RUN_BIT];
          if (!run_q) begin  // mode and prescale locked while counting
            mode_q <= wdata_i[MODE_LSB +: MODE_W];
            sel_q  <= wdata_i[SEL_LSB +: SEL_W];
          end
        end
        ADDR_DIR:  dir_q <= wdata_i[1:0];
        ADDR_PIN:
          for (int g = 0; g < NUM_PINS; g++) begin
            code_q[g] <= wdata_i[PIN_STRIDE*g +: CODE_W];
            oe_q[g]   <= wdata_i[PIN_STRIDE*g + OE_OFS];
          end
        ADDR_CMPA: cmp_q[0] <= wdata_i;
        ADDR_CMPB: cmp_q[1] <= wdata_i;
        ADDR_PER:  per_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[RUN_BIT]              = run_q;
        rdata_o[MODE_LSB +: MODE_W]   = mode_q;
        rdata_o[SEL_LSB +: SEL_W]     = sel_q;
      end
      ADDR_DIR:  rdata_o[1:0] = dir_q;
      ADDR_PIN:
        for (int g = 0; g < NUM_PINS; g++) begin
          rdata_o[PIN_STRIDE*g +: CODE_W]  = code_q[g];
          rdata_o[PIN_STRIDE*g + OE_OFS]   = oe_q[g];
        end
      ADDR_CNT:  rdata_o = cnt;
      ADDR_CMPA: rdata_o = cmp_q[0];
      ADDR_CMPB: rdata_o = cmp_q[1];
      ADDR_PER:  rdata_o = per_q;
      default: ;
    endcase
  end

  pwm_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_presc (
    .clk_i, .rst_ni, .run_i(run_q), .sel_i(sel_q), .tick_o(tick)
  );

  pwm_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .up_i(dir_q[0]), .load_i(cnt_load),
    .load_val_i(wdata_i), .period_i(per_q), .cnt_o(cnt), .end_o(per_end),
    .ovf_o(ovf_o)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign match[g] = step && (cnt == cmp_q[g]);
    pwm_pin u_pin (
      .clk_i, .rst_ni, .run_i(run_q), .start_i(start), .end_i(per_end),
      .match_i(match[g]), .code_i(code_q[g]), .oe_i(oe_q[g]),
      .pin_o(pin_o[g]), .oe_o(pin_oe_o[g])
    );
  end

  assert_mode_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(mode_q) && $stable(sel_q)));
  assert_idle_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> pin_o == '0);
endmodule

// File: tb/pwm_saw_timer_bench.sv
module pwm_saw_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  pin, pin_oe;
  logic        ovf;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h2C, A_DIR = 8'h30, A_PIN = 8'h34,
    A_CNT = 8'h48, A_CMPA = 8'h4C, A_CMPB = 8'h50, A_PER = 8'h64, A_NONE = 8'h40;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_saw_timer u_pwm_saw_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin), .pin_oe_o(pin_oe), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic stop_clean();
    wr(A_CTRL, 0); wr(A_CTRL, 0);  // second write clears mode/select once stopped
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 dir", A_DIR, 1);
    rd_chk("R1 pin", A_PIN, 0);
    rd_chk("R1 cnt", A_CNT, 0);
    rd_chk("R1 per", A_PER, 32'hFFFF_FFFF);
    rd_chk("R1 cmpa", A_CMPA, 0);
    chk("R1 outputs", {pin, pin_oe, ovf}, 0);
  endtask

  task automatic t_regs();
    wr(A_CMPA, 32'h1234_5678); rd_chk("R2 cmpa", A_CMPA, 32'h1234_5678);
    wr(A_CMPB, 32'h0BAD_F00D); rd_chk("R2 cmpb", A_CMPB, 32'h0BAD_F00D);
    wr(A_PIN, 32'hFFFF_FFFF);  rd_chk("R2 pin mask", A_PIN, 32'h011F_011F);
    wr(A_DIR, 32'hFFFF_FFFF);  rd_chk("R2 dir mask", A_DIR, 3);
    wr(A_CTRL, 32'h0700_0000 | (32'h7 << 16)); rd_chk("R2 ctrl", A_CTRL, 32'h0707_0000);
    wr(A_NONE, 32'hFFFF_FFFF); rd_chk("R2 unmapped", A_NONE, 0);
    stop_clean(); wr(A_DIR, 3); wr(A_PIN, 0);
    rd_chk("R2 ctrl cleared", A_CTRL, 0);
  endtask

  task automatic t_up();
    logic [31:0] c;
    wr(A_PER, 4); wr(A_CMPA, 1); wr(A_CMPB, 2);
    wr(A_PIN, 32'h0107_011B); wr(A_CNT, 0);
    wr(A_CTRL, 1);
    for (int k = 0; k < 12; k++) begin
      c = k % 5;
      rd_chk("R5 up count", A_CNT, c);
      chk("R8 pin A high code", pin[0], c <= 1);
      chk("R8 pin B low code", pin[1], c > 2);
      chk("R5 ovf", ovf, (k > 0 && c == 0));
      @(negedge clk);
    end
    stop_clean();
    chk("R11 stopped low", pin, 0);
    chk("R11 oe", pin_oe, 2'b11);
  endtask

  task automatic t_coincide();
    wr(A_PER, 3); wr(A_CMPA, 3); wr(A_CMPB, 3);
    wr(A_PIN, 32'h011B_0107); wr(A_CNT, 0);
    wr(A_CTRL, 1);
    for (int k = 0; k < 10; k++) begin
      chk("R9 end wins A", pin[0], 0);
      chk("R9 end wins B", pin[1], 1);
      @(negedge clk);
    end
  endtask

  task automatic t_lock();
    logic [31:0] a, b;
    // still running from t_coincide
    wr(A_CTRL, 32'h0201_0001);
    rd_chk("R3 locked", A_CTRL, 1);
    rd(A_CNT, a); @(negedge clk); rd(A_CNT, b);
    chk("R3 still counting", b, (a + 1) % 4);
    wr(A_CTRL, 0);
    wr(A_CTRL, 32'h0001_0000); rd_chk("R3 accepted stopped", A_CTRL, 32'h0001_0000);
    wr(A_CNT, 2); rd_chk("R12 load", A_CNT, 2);
    wr(A_CTRL, 32'h0001_0001);
    repeat (5) @(negedge clk);
    rd_chk("R7 frozen", A_CNT, 2);
    wr(A_CNT, 32'hCAFE_0001); rd_chk("R12 load running", A_CNT, 32'hCAFE_0001);
    stop_clean();
  endtask

  task automatic t_prescale();
    wr(A_CTRL, 32'h0100_0000); rd_chk("R4 sel stored", A_CTRL, 32'h0100_0000);
    wr(A_CNT, 0); wr(A_PER, 2);
    wr(A_CTRL, 32'h0100_0001);
    for (int k = 0; k < 14; k++) begin
      rd_chk("R4 div4", A_CNT, (k / 4) % 3);
      @(negedge clk);
    end
    stop_clean();
    wr(A_CTRL, 32'h0700_0000); rd_chk("R4 sel7 stored", A_CTRL, 32'h0700_0000);
    wr(A_CNT, 0); wr(A_PER, 100);
    wr(A_CTRL, 32'h0700_0001);
    repeat (1023) @(negedge clk);
    rd_chk("R4 sel7 before", A_CNT, 0);
    @(negedge clk);
    rd_chk("R4 sel7 tick", A_CNT, 1);
    stop_clean();
  endtask

  task automatic t_down();
    wr(A_DIR, 2); wr(A_PER, 3); wr(A_CNT, 3);
    wr(A_CTRL, 1);
    for (int k = 0; k < 9; k++) begin
      rd_chk("R6 down count", A_CNT, 3 - (k % 4));
      chk("R6 ovf", ovf, (k > 0 && k % 4 == 0));
      @(negedge clk);
    end
    stop_clean(); wr(A_DIR, 3);
  endtask

  task automatic t_hold();
    wr(A_PER, 4); wr(A_CMPA, 1); wr(A_PIN, 32'h0000_011B); wr(A_CNT, 0);
    wr(A_CTRL, 1);  // level A set high
    stop_clean();
    wr(A_PIN, 32'h0000_0105); wr(A_CNT, 0);
    wr(A_CTRL, 1);
    for (int k = 0; k < 12; k++) begin
      chk("R10 hold level", pin[0], 1);
      @(negedge clk);
    end
    wr(A_PIN, 32'h0000_0005);
    chk("R11 disabled pin", pin[0], 0);
    chk("R11 disabled oe", pin_oe[0], 0);
    stop_clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_up();
    t_coincide();
    t_lock();
    t_prescale();
    t_down();
    t_hold();
    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end
endmodule